// File: doc/BRIEF.md
# Asynchronous Memory Read Timing Sequencer

This block produces the control waveforms for one read of an asynchronous external memory. A requester offers an address and a device index on a valid/ready handshake. The block then drives the address bus, pulls the shared active-low read strobe and the addressed device's active-low select low in programmed windows, and samples the data bus. The captured word comes back as a single-cycle response.

Every device index has its own timing set, all counted in clock cycles: strobe setup, strobe width, select setup, select width, and the total length of the read. The hold times are not programmed. Each one is whatever is left of the total length after its setup and width. If a setup plus its width exceeds the programmed length, the read is lengthened to fit and that hold becomes zero.

A new request is taken only while the block is idle or in the last cycle of the current read. Back-to-back reads of the same device therefore run without a break, and a signal whose setup and hold are both zero stays asserted from one read into the next. A change of device, or an idle gap, always lets the strobes go high before the next read starts.

Top module: `srt_read_timing`

## Requirements
- R1: While reset is held, mem_rd_n is 1, every mem_cs_n bit is 1, rsp_valid is 0 and req_ready is 1.
- R2: Number the cycles of a read t = 0, 1, ... starting with the first cycle after acceptance (or after the gap of R8). mem_rd_n is 0 exactly when rd_setup <= t < rd_setup + rd_pulse, using the addressed device's settings.
- R3: mem_cs_n bit k, where k is the accepted req_cs, is 0 exactly when cs_setup <= t < cs_setup + cs_pulse. All other select bits stay 1.
- R4: A read lasts L = max(cycle, rd_setup + rd_pulse, cs_setup + cs_pulse, 1) cycles. req_ready is 1 only in cycle t = L-1 or while idle.
- R5: mem_addr shows the accepted req_addr for the whole read and changes only on a clock edge at which a request is accepted.
- R6: mem_rdata is sampled at the end of cycle t = rd_setup + rd_pulse - 1. rsp_valid is 1 for the following cycle, with that word on rsp_data, and is 0 in every other cycle.
- R7: For a device with zero setup and zero derived hold, consecutive reads accepted in each read's last cycle keep mem_rd_n and that device's mem_cs_n at 0 with no high cycle between them.
- R8: A request for a different device accepted in the last cycle of a read is followed by one cycle with all strobes high and req_ready 0. Cycle t = 0 of the new read comes after that cycle.
- R9: If no request is accepted in the last cycle, the next cycle has all strobes high and req_ready 1.
- R10: Each device index uses only its own timing set, taken from bit slice [k*5 +: 5] of each cfg_* port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request offered |
| req_ready | output | 1 | Request taken on this edge if valid |
| req_addr | input | ADDR_W | Read address |
| req_cs | input | CS_W | Device index |
| rsp_valid | output | 1 | One-cycle read data valid |
| rsp_data | output | DATA_W | Captured read word |
| cfg_rd_setup | input | NUM_CS*5 | Read-strobe setup per device |
| cfg_rd_pulse | input | NUM_CS*5 | Read-strobe width per device |
| cfg_cs_setup | input | NUM_CS*5 | Select setup per device |
| cfg_cs_pulse | input | NUM_CS*5 | Select width per device |
| cfg_cycle | input | NUM_CS*5 | Total read length per device |
| mem_addr | output | ADDR_W | External address bus |
| mem_rd_n | output | 1 | Active-low read strobe |
| mem_cs_n | output | NUM_CS | Active-low device selects |
| mem_rdata | input | DATA_W | External data bus |

## Verification
The assertions rely on three things about the inputs. The cfg_* ports change only while the block is idle. Every pulse width is at least one cycle, so each read has a sampling cycle. req_cs is below NUM_CS. The stimulus follows all three: it draws pulse widths from 1 upward, draws device indices only from the implemented range, and changes a device's timing set only after an idle cycle has been observed.

// File: rtl/srt_pkg.sv
package srt_pkg;

    localparam int CNT_W = 5;
    localparam int LEN_W = CNT_W + 1;

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [LEN_W-1:0] len_t;

    typedef struct packed {
        cnt_t rd_setup;
        cnt_t rd_pulse;
        cnt_t cs_setup;
        cnt_t cs_pulse;
        cnt_t cycle;
    } tset_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_GAP  = 2'd1,
        ST_RUN  = 2'd2
    } seq_st_t;

    // end (exclusive) of a setup/width window
    function automatic len_t win_end(cnt_t setup, cnt_t width);
        return len_t'(setup) + len_t'(width);
    endfunction

    // effective read length: programmed length, stretched to fit both windows, never zero
    function automatic len_t eff_len(tset_t ts);
        len_t l;
        l = len_t'(ts.cycle);
        if (win_end(ts.rd_setup, ts.rd_pulse) > l) l = win_end(ts.rd_setup, ts.rd_pulse);
        if (win_end(ts.cs_setup, ts.cs_pulse) > l) l = win_end(ts.cs_setup, ts.cs_pulse);
        if (l == '0) l = len_t'(1);
        return l;
    endfunction

endpackage

// File: rtl/srt_tset_mux.sv
module srt_tset_mux
    import srt_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int CS_W   = 2
) (
    input  logic [NUM_CS*CNT_W-1:0] cfg_rd_setup,
    input  logic [NUM_CS*CNT_W-1:0] cfg_rd_pulse,
    input  logic [NUM_CS*CNT_W-1:0] cfg_cs_setup,
    input  logic [NUM_CS*CNT_W-1:0] cfg_cs_pulse,
    input  logic [NUM_CS*CNT_W-1:0] cfg_cycle,
    input  logic [CS_W-1:0]         sel,
    output tset_t                   tset,
    output len_t                    len
);

    tset_t bank [NUM_CS];

    for (genvar k = 0; k < NUM_CS; k++) begin : g_bank
        assign bank[k].rd_setup = cfg_rd_setup[k*CNT_W +: CNT_W];
        assign bank[k].rd_pulse = cfg_rd_pulse[k*CNT_W +: CNT_W];
        assign bank[k].cs_setup = cfg_cs_setup[k*CNT_W +: CNT_W];
        assign bank[k].cs_pulse = cfg_cs_pulse[k*CNT_W +: CNT_W];
        assign bank[k].cycle    = cfg_cycle[k*CNT_W +: CNT_W];
    end

    always_comb begin
        tset = '0;
        for (int k = 0; k < NUM_CS; k++) begin
            if (sel == CS_W'(k)) tset = bank[k];
        end
        len = eff_len(tset);
    end

endmodule

// File: rtl/srt_strobe_win.sv
module srt_strobe_win
    import srt_pkg::*;
(
    input  logic en,
    input  len_t t,
    input  cnt_t setup,
    input  cnt_t width,
    output logic active
);

    always_comb begin
        active = en && (t >= len_t'(setup)) && (t < win_end(setup, width));
    end

endmodule

// File: rtl/srt_seq.sv
module srt_seq
    import srt_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CS_W   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CS_W-1:0]   req_cs,
    input  len_t              len,
    output logic              req_ready,
    output logic              running,
    output len_t              t,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CS_W-1:0]   cur_cs
);

    seq_st_t st_q;
    logic    last_cyc;
    logic    take;

    always_comb begin
        last_cyc  = (st_q == ST_RUN) && (t == len - len_t'(1));
        req_ready = (st_q == ST_IDLE) || last_cyc;
        take      = req_valid && req_ready;
        running   = (st_q == ST_RUN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            t        <= '0;
            cur_addr <= '0;
            cur_cs   <= '0;
        end else if (take) begin
            cur_addr <= req_addr;
            cur_cs   <= req_cs;
            t        <= '0;
            st_q     <= (st_q == ST_RUN && req_cs != cur_cs) ? ST_GAP : ST_RUN;
        end else begin
            case (st_q)
                ST_GAP: begin
                    st_q <= ST_RUN;
                    t    <= '0;
                end
                ST_RUN: begin
                    if (last_cyc) begin
                        st_q <= ST_IDLE;
                        t    <= '0;
                    end else begin
                        t <= t + len_t'(1);
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/srt_read_timing.sv
module srt_read_timing
    import srt_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [CS_W-1:0]         req_cs,
    output logic                    rsp_valid,
    output logic [DATA_W-1:0]       rsp_data,
    input  logic [NUM_CS*CNT_W-1:0] cfg_rd_setup,
    input  logic [NUM_CS*CNT_W-1:0] cfg_rd_pulse,
    input  logic [NUM_CS*CNT_W-1:0] cfg_cs_setup,
    input  logic [NUM_CS*CNT_W-1:0] cfg_cs_pulse,
    input  logic [NUM_CS*CNT_W-1:0] cfg_cycle,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic                    mem_rd_n,
    output logic [NUM_CS-1:0]       mem_cs_n,
    input  logic [DATA_W-1:0]       mem_rdata
);

    tset_t           tset;
    len_t            len;
    len_t            t;
    logic            running;
    logic [CS_W-1:0] cur_cs;
    logic            rd_act;
    logic            cs_act;
    logic            rd_last;

    srt_tset_mux #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_mux (
        .cfg_rd_setup (cfg_rd_setup),
        .cfg_rd_pulse (cfg_rd_pulse),
        .cfg_cs_setup (cfg_cs_setup),
        .cfg_cs_pulse (cfg_cs_pulse),
        .cfg_cycle    (cfg_cycle),
        .sel          (cur_cs),
        .tset         (tset),
        .len          (len)
    );

    srt_seq #(.ADDR_W(ADDR_W), .CS_W(CS_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_cs    (req_cs),
        .len       (len),
        .req_ready (req_ready),
        .running   (running),
        .t         (t),
        .cur_addr  (mem_addr),
        .cur_cs    (cur_cs)
    );

    srt_strobe_win u_rd_win (
        .en     (running),
        .t      (t),
        .setup  (tset.rd_setup),
        .width  (tset.rd_pulse),
        .active (rd_act)
    );

    srt_strobe_win u_cs_win (
        .en     (running),
        .t      (t),
        .setup  (tset.cs_setup),
        .width  (tset.cs_pulse),
        .active (cs_act)
    );

    assign mem_rd_n = !rd_act;
    assign rd_last  = rd_act && (t == win_end(tset.rd_setup, tset.rd_pulse) - len_t'(1));

    for (genvar k = 0; k < NUM_CS; k++) begin : g_sel
        assign mem_cs_n[k] = !(cs_act && (cur_cs == CS_W'(k)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= rd_last;
            if (rd_last) rsp_data <= mem_rdata;
        end
    end

endmodule

// File: rtl/srt_read_timing_chk.sv
module srt_read_timing_chk #(
    parameter int NUM_CS = 4,
    parameter int ADDR_W = 16,
    parameter int CS_W   = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [CS_W-1:0]   req_cs,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rd_n,
    input logic [NUM_CS-1:0] mem_cs_n,
    input logic              rsp_valid
);

    // R3: at most one device selected
    a_r3_one_select: assert property (@(posedge clk) disable iff (rst)
        $countones(~mem_cs_n) <= 1);

    // R5: address moves only on an accepting edge
    a_r5_addr_hold: assert property (@(posedge clk) disable iff (rst)
        !$past(req_valid && req_ready) |-> $stable(mem_addr));

    // R6: a response follows a cycle with the read strobe low
    a_r6_rsp_after_strobe: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(!mem_rd_n));

    // R8: switching device while selected inserts an all-high cycle
    a_r8_switch_gap: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && (mem_cs_n != '1) && ((~mem_cs_n) != (NUM_CS'(1) << req_cs)))
        |=> (mem_rd_n && (mem_cs_n == '1) && !req_ready));

    // R9: no request when ready leaves the bus released
    a_r9_release: assert property (@(posedge clk) disable iff (rst)
        (req_ready && !req_valid) |=> (mem_rd_n && (mem_cs_n == '1) && req_ready));

endmodule

bind srt_read_timing srt_read_timing_chk #(
    .NUM_CS (NUM_CS),
    .ADDR_W (ADDR_W),
    .CS_W   (CS_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_cs    (req_cs),
    .mem_addr  (mem_addr),
    .mem_rd_n  (mem_rd_n),
    .mem_cs_n  (mem_cs_n),
    .rsp_valid (rsp_valid)
);

// File: tb/tb_srt_read_timing.sv
`timescale 1ns/1ps
module tb_srt_read_timing;
    import srt_pkg::*;

    localparam int NUM_CS = 4;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 16;
    localparam int CS_W   = 2;

    logic clk = 1'b0;
    logic rst;
    logic req_valid;
    logic req_ready;
    logic [ADDR_W-1:0] req_addr;
    logic [CS_W-1:0]   req_cs;
    logic rsp_valid;
    logic [DATA_W-1:0] rsp_data;
    logic [NUM_CS*CNT_W-1:0] f_rs, f_rp, f_cs, f_cp, f_cy;
    logic [ADDR_W-1:0] mem_addr;
    logic mem_rd_n;
    logic [NUM_CS-1:0] mem_cs_n;
    logic [DATA_W-1:0] mem_rdata;

    int c_rs [NUM_CS];
    int c_rp [NUM_CS];
    int c_cs [NUM_CS];
    int c_cp [NUM_CS];
    int c_cy [NUM_CS];

    int checks = 0;
    int errors = 0;
    bit pend = 1'b0;
    logic [DATA_W-1:0] pend_data;
    int rd_high_cnt;
    int cs_high_cnt;

    always #2 clk = ~clk;

    assign mem_rdata = mem_addr ^ 16'h5A3C;

    always_comb begin
        for (int k = 0; k < NUM_CS; k++) begin
            f_rs[k*CNT_W +: CNT_W] = CNT_W'(c_rs[k]);
            f_rp[k*CNT_W +: CNT_W] = CNT_W'(c_rp[k]);
            f_cs[k*CNT_W +: CNT_W] = CNT_W'(c_cs[k]);
            f_cp[k*CNT_W +: CNT_W] = CNT_W'(c_cp[k]);
            f_cy[k*CNT_W +: CNT_W] = CNT_W'(c_cy[k]);
        end
    end

    srt_read_timing #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
        .clk (clk), .rst (rst),
        .req_valid (req_valid), .req_ready (req_ready),
        .req_addr (req_addr), .req_cs (req_cs),
        .rsp_valid (rsp_valid), .rsp_data (rsp_data),
        .cfg_rd_setup (f_rs), .cfg_rd_pulse (f_rp),
        .cfg_cs_setup (f_cs), .cfg_cs_pulse (f_cp), .cfg_cycle (f_cy),
        .mem_addr (mem_addr), .mem_rd_n (mem_rd_n),
        .mem_cs_n (mem_cs_n), .mem_rdata (mem_rdata)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_len(int k);
        int l = c_cy[k];
        if (c_rs[k] + c_rp[k] > l) l = c_rs[k] + c_rp[k];
        if (c_cs[k] + c_cp[k] > l) l = c_cs[k] + c_cp[k];
        if (l < 1) l = 1;
        return l;
    endfunction

    function automatic bit in_win(int t, int s, int w);
        return (t >= s) && (t < s + w);
    endfunction

    // advance one cycle, sample at the falling edge, check the response (R6)
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        if (pend) begin
            chk(rsp_valid == 1'b1, "R6 rsp_valid", int'(rsp_valid), 1);
            chk(rsp_data == pend_data, "R6 rsp_data", int'(rsp_data), int'(pend_data));
        end else begin
            chk(rsp_valid == 1'b0, "R6 rsp_valid idle", int'(rsp_valid), 0);
        end
        pend = 1'b0;
    endtask

    // one read; returns at the sample point of its last cycle
    task automatic do_read(input int k, input logic [ADDR_W-1:0] a, input bit gap);
        int l;
        logic [NUM_CS-1:0] exp_cs;
        chk(req_ready == 1'b1, "R4 ready before issue", int'(req_ready), 1);
        req_valid = 1'b1;
        req_addr  = a;
        req_cs    = CS_W'(k);
        tick();
        req_valid = 1'b0;
        if (gap) begin
            chk(mem_rd_n == 1'b1, "R8 gap rd_n", int'(mem_rd_n), 1);
            chk(mem_cs_n == '1, "R8 gap cs_n", int'(mem_cs_n), (1 << NUM_CS) - 1);
            chk(req_ready == 1'b0, "R8 gap ready", int'(req_ready), 0);
            tick();
        end
        l = exp_len(k);
        for (int t = 0; t < l; t++) begin
            if (t > 0) tick();
            exp_cs = '1;
            if (in_win(t, c_cs[k], c_cp[k])) exp_cs[k] = 1'b0;
            chk(mem_rd_n == !in_win(t, c_rs[k], c_rp[k]), "R2 rd_n",
                int'(mem_rd_n), int'(!in_win(t, c_rs[k], c_rp[k])));
            chk(mem_cs_n == exp_cs, "R3 R10 cs_n", int'(mem_cs_n), int'(exp_cs));
            chk(mem_addr == a, "R5 addr", int'(mem_addr), int'(a));
            chk(req_ready == (t == l - 1), "R4 ready timing", int'(req_ready), int'(t == l - 1));
            if (mem_rd_n) rd_high_cnt++;
            if (mem_cs_n[k]) cs_high_cnt++;
            if (t == c_rs[k] + c_rp[k] - 1) begin
                pend = 1'b1;
                pend_data = a ^ 16'h5A3C;
            end
        end
    endtask

    task automatic idle_cycle();
        tick();
        chk(mem_rd_n == 1'b1, "R9 idle rd_n", int'(mem_rd_n), 1);
        chk(mem_cs_n == '1, "R9 idle cs_n", int'(mem_cs_n), (1 << NUM_CS) - 1);
        chk(req_ready == 1'b1, "R9 idle ready", int'(req_ready), 1);
    endtask

    task automatic set_cfg(input int k, input int rs, input int rp, input int cs, input int cp, input int cy);
        c_rs[k] = rs; c_rp[k] = rp; c_cs[k] = cs; c_cp[k] = cp; c_cy[k] = cy;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R4: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int last_k;
        bit busy;
        void'($urandom(32'd20240611));
        rst = 1'b1;
        req_valid = 1'b0;
        req_addr = '0;
        req_cs = '0;
        set_cfg(0, 1, 3, 0, 5, 7);
        set_cfg(1, 0, 4, 0, 4, 4);
        set_cfg(2, 3, 4, 1, 2, 2);
        set_cfg(3, 2, 2, 1, 4, 10);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(mem_rd_n == 1'b1, "R1 rd_n", int'(mem_rd_n), 1);
        chk(mem_cs_n == '1, "R1 cs_n", int'(mem_cs_n), (1 << NUM_CS) - 1);
        chk(rsp_valid == 1'b0, "R1 rsp_valid", int'(rsp_valid), 0);
        chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
        rst = 1'b0;
        @(negedge clk);

        // plain read with derived holds, then release (R2 R3 R9)
        do_read(0, 16'h1111, 1'b0);
        idle_cycle();

        // stretched read: setup+width beyond programmed length (R4)
        do_read(2, 16'h2222, 1'b0);
        idle_cycle();

        // zero setup/hold chained to the same device (R7)
        rd_high_cnt = 0;
        cs_high_cnt = 0;
        do_read(1, 16'h3330, 1'b0);
        do_read(1, 16'h3331, 1'b0);
        do_read(1, 16'h3332, 1'b0);
        chk(rd_high_cnt == 0, "R7 rd_n continuous", rd_high_cnt, 0);
        chk(cs_high_cnt == 0, "R7 cs_n continuous", cs_high_cnt, 0);

        // device switch while chained: gap cycle (R8), then different timing set (R10)
        do_read(0, 16'h4444, 1'b1);
        do_read(3, 16'h5555, 1'b1);
        idle_cycle();

        // constrained random mix
        busy = 1'b0;
        last_k = 0;
        for (int i = 0; i < 400; i++) begin
            if (busy && ($urandom % 4 == 0)) begin
                idle_cycle();
                busy = 1'b0;
            end else if (!busy && ($urandom % 3 == 0)) begin
                set_cfg($urandom % NUM_CS, $urandom_range(0, 4), $urandom_range(1, 4),
                        $urandom_range(0, 4), $urandom_range(1, 6), $urandom_range(0, 12));
                idle_cycle();
            end else begin
                int k = $urandom % NUM_CS;
                do_read(k, 16'($urandom), busy && (k != last_k));
                last_k = k;
                busy = 1'b1;
            end
        end
        idle_cycle();
        idle_cycle();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule